// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Address Generator

This block produces the word read addresses that a display pixel fetcher issues over one frame. Software may write a new frame base address at any moment; the block holds that value in a shadow position. It copies it into the live base only at the next frame-start strobe, so panning or page flipping never tears a frame. The base in use is always visible on a read-back output.

The frame geometry comes from a packed transfer-count word, which holds a line count and a pixel count, and from a pixel-size select. From these the block derives the line stride and the number of 32-bit words per line. It walks the frame line by line and word by word, and it moves on only when the downstream side accepts a request. Clearing the run control stops new requests without dropping one already on offer. The run status stays high until the pixel FIFO reports empty. A FIFO-clear control abandons the rest of the current frame.

The control FSM has four states. ST_IDLE goes to ST_ARM when run is set. ST_ARM goes to ST_FETCH on a frame start with a non-empty geometry, or to ST_DRAIN when run is cleared. ST_FETCH goes back to ST_ARM after the last word is accepted or on FIFO clear with run still set, and to ST_DRAIN when run is low at that point or when a request is accepted after run was cleared. ST_DRAIN goes to ST_IDLE when the FIFO reports empty.

Top module: `ffa_fetch_gen`

## Requirements
- R1: After reset, rd_valid_o is 0, running_o is 0 and cur_base_o is 0.
- R2: xfer_count_i[31:16] is the number of lines and xfer_count_i[15:0] the number of pixels per line. With wide_pix_i=1 a pixel takes 4 bytes and a line has as many words as pixels. With wide_pix_i=0 a pixel takes 2 bytes and a line has ceil(pixels/2) words. The stride is pixels times bytes per pixel.
- R3: The request for line L, word W carries the address base + L*stride + 4*W. Requests are issued in order of rising W within a line and rising L.
- R4: The address advances only in a cycle where rd_valid_o and req_ready_i are both 1. While req_ready_i is 0, rd_valid_o and rd_addr_o hold their values.
- R5: cur_base_o takes the value of next_base_i only on a frame-start strobe seen while armed. Writes to next_base_i at any other time change neither cur_base_o nor the addresses issued.
- R6: A frame-start strobe that arrives while a frame is being fetched is ignored.
- R7: After the last word of the last line is accepted, rd_valid_o stays 0 until the next frame-start strobe.
- R8: The geometry inputs are captured at frame start. Changes to them during the frame do not alter that frame.
- R9: Once run_i is 0, no further request follows the one being accepted. running_o stays 1 until fifo_empty_i is seen high, and falls one cycle later.
- R10: fifo_clear_i during a fetch drops rd_valid_o in the next cycle. The rest of the frame is abandoned, and fetching restarts at line 0 on the next frame start.
- R11: A frame start with a zero line or pixel count still swaps the base but issues no request.
- R12: running_o rises one cycle after run_i is set from idle. A frame-start strobe while not running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run control |
| fifo_clear_i | input | 1 | Abandon the buffered frame |
| frame_start_i | input | 1 | Frame-start (vertical sync) strobe |
| fifo_empty_i | input | 1 | Pixel FIFO is empty |
| next_base_i | input | 32 | Shadow base address for the next frame |
| xfer_count_i | input | 32 | Lines in [31:16], pixels per line in [15:0] |
| wide_pix_i | input | 1 | 1: 4 bytes per pixel, 0: 2 bytes per pixel |
| req_ready_i | input | 1 | Downstream accepts the request |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read word address |
| cur_base_o | output | 32 | Base address of the frame in use |
| running_o | output | 1 | Run status |

## Verification
Every result is due one clock edge after the input that causes it. A frame start puts the first address on rd_addr_o after that edge. An accepted request shows the next address after the same edge. A clear or a stop drops rd_valid_o after the edge on which it is sampled. running_o falls after the edge on which fifo_empty_i is seen high. The bench drives inputs and samples outputs one nanosecond after each rising edge, steps exactly one edge between a stimulus and its check, and computes every expected address from the stride formula, not from the design.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_FETCH = 2'd2,
        ST_DRAIN = 2'd3
    } ffa_state_e;
endpackage

// File: rtl/ffa_base_shadow.sv
module ffa_base_shadow #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] next_base_i,
    output logic [ADDR_W-1:0] cur_base_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_base_o <= '0;
        else if (load_i)
            cur_base_o <= next_base_i;
    end
endmodule

// File: rtl/ffa_addr_walk.sv
module ffa_addr_walk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               advance_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [2*CNT_W-1:0] xfer_count_i,
    input  logic               wide_pix_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               frame_last_o,
    output logic               frame_empty_o
);
    localparam int STRIDE_W = CNT_W + 2;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0]    pix_in, lines_in, words_in;
    logic [STRIDE_W-1:0] stride_in;

    logic [CNT_W-1:0]    words_q, lines_q, word_q, line_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [ADDR_W-1:0]   line_base_q;
    logic                last_word;

    always_comb begin
        pix_in        = xfer_count_i[CNT_W-1:0];
        lines_in      = xfer_count_i[2*CNT_W-1:CNT_W];
        words_in      = wide_pix_i ? pix_in
                                   : (pix_in >> 1) + {{(CNT_W-1){1'b0}}, pix_in[0]};
        stride_in     = wide_pix_i ? {pix_in, 2'b00} : {1'b0, pix_in, 1'b0};
        frame_empty_o = (pix_in == '0) || (lines_in == '0);
        last_word     = (word_q == words_q - ONE_C);
        frame_last_o  = last_word && (line_q == lines_q - ONE_C);
        addr_o        = line_base_q + ADDR_W'({word_q, 2'b00});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q     <= '0;
            lines_q     <= '0;
            stride_q    <= '0;
            word_q      <= '0;
            line_q      <= '0;
            line_base_q <= '0;
        end else if (load_i) begin
            words_q     <= words_in;
            lines_q     <= lines_in;
            stride_q    <= stride_in;
            word_q      <= '0;
            line_q      <= '0;
            line_base_q <= base_i;
        end else if (advance_i) begin
            if (last_word) begin
                word_q      <= '0;
                line_q      <= line_q + ONE_C;
                line_base_q <= line_base_q + ADDR_W'(stride_q);
            end else begin
                word_q      <= word_q + ONE_C;
            end
        end
    end
endmodule

// File: rtl/ffa_ctrl_fsm.sv
module ffa_ctrl_fsm
    import ffa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fifo_clear_i,
    input  logic frame_start_i,
    input  logic fifo_empty_i,
    input  logic req_ready_i,
    input  logic frame_last_i,
    input  logic frame_empty_i,
    output logic load_o,
    output logic advance_o,
    output logic req_valid_o,
    output logic running_o
);
    ffa_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i)
                    state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!run_i)
                    state_d = ST_DRAIN;
                else if (frame_start_i && !frame_empty_i)
                    state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (fifo_clear_i)
                    state_d = run_i ? ST_ARM : ST_DRAIN;
                else if (req_ready_i && (frame_last_i || !run_i))
                    state_d = run_i ? ST_ARM : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (fifo_empty_i)
                    state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        load_o      = (state_q == ST_ARM) && run_i && frame_start_i;
        req_valid_o = (state_q == ST_FETCH);
        advance_o   = (state_q == ST_FETCH) && req_ready_i && !fifo_clear_i;
        running_o   = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/ffa_fetch_gen.sv
module ffa_fetch_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               fifo_clear_i,
    input  logic               frame_start_i,
    input  logic               fifo_empty_i,
    input  logic [ADDR_W-1:0]  next_base_i,
    input  logic [2*CNT_W-1:0] xfer_count_i,
    input  logic               wide_pix_i,
    input  logic               req_ready_i,
    output logic               rd_valid_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic [ADDR_W-1:0]  cur_base_o,
    output logic               running_o
);
    logic load, advance, frame_last, frame_empty;

    ffa_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .fifo_clear_i  (fifo_clear_i),
        .frame_start_i (frame_start_i),
        .fifo_empty_i  (fifo_empty_i),
        .req_ready_i   (req_ready_i),
        .frame_last_i  (frame_last),
        .frame_empty_i (frame_empty),
        .load_o        (load),
        .advance_o     (advance),
        .req_valid_o   (rd_valid_o),
        .running_o     (running_o)
    );

    ffa_base_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .next_base_i (next_base_i),
        .cur_base_o  (cur_base_o)
    );

    ffa_addr_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .advance_i     (advance),
        .base_i        (next_base_i),
        .xfer_count_i  (xfer_count_i),
        .wide_pix_i    (wide_pix_i),
        .addr_o        (rd_addr_o),
        .frame_last_o  (frame_last),
        .frame_empty_o (frame_empty)
    );
endmodule

// File: rtl/ffa_fetch_gen_chk.sv
module ffa_fetch_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_i,
    input logic               fifo_clear_i,
    input logic               frame_start_i,
    input logic               fifo_empty_i,
    input logic [ADDR_W-1:0]  next_base_i,
    input logic [2*CNT_W-1:0] xfer_count_i,
    input logic               wide_pix_i,
    input logic               req_ready_i,
    input logic               rd_valid_o,
    input logic [ADDR_W-1:0]  rd_addr_o,
    input logic [ADDR_W-1:0]  cur_base_o,
    input logic               running_o
);
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !req_ready_i && !fifo_clear_i |=> rd_valid_o && $stable(rd_addr_o));

    assert_base_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(cur_base_o));

    assert_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o && !frame_start_i |=> !rd_valid_o);

    assert_graceful_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && !fifo_empty_i |=> running_o);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear_i |=> !rd_valid_o);

    assert_run_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> running_o);
endmodule

bind ffa_fetch_gen ffa_fetch_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/ffa_fetch_gen_tb_top.sv
`timescale 1ns/1ps
module ffa_fetch_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        fifo_clear_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        fifo_empty_i = 1'b0;
    logic [31:0] next_base_i = '0;
    logic [31:0] xfer_count_i = '0;
    logic        wide_pix_i = 1'b1;
    logic        req_ready_i = 1'b1;
    logic        rd_valid_o;
    logic [31:0] rd_addr_o;
    logic [31:0] cur_base_o;
    logic        running_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ffa_fetch_gen dut_i (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic start_frame();
        frame_start_i = 1'b1;
        step();
        frame_start_i = 1'b0;
    endtask

    // Walks one whole frame, with or without back-pressure on every word (R2 R3 R4 R7)
    task automatic walk_frame(input logic [31:0] base, input int pix, input int lines,
                              input bit wide, input bit stall);
        int bpp   = wide ? 4 : 2;
        int words = wide ? pix : (pix + 1) / 2;
        int strd  = pix * bpp;
        for (int l = 0; l < lines; l++) begin
            for (int w = 0; w < words; w++) begin
                logic [31:0] exp = base + 32'(l * strd) + 32'(4 * w);
                if (stall) begin
                    req_ready_i = 1'b0;
                    chk("R3", rd_addr_o, exp);
                    step();
                    chk("R4", {31'd0, rd_valid_o}, 32'd1);
                    chk("R4", rd_addr_o, exp);
                    req_ready_i = 1'b1;
                end
                chk("R2", {31'd0, rd_valid_o}, 32'd1);
                chk("R3", rd_addr_o, exp);
                step();
            end
        end
        for (int k = 0; k < 4; k++) begin
            chk("R7", {31'd0, rd_valid_o}, 32'd0);
            step();
        end
    endtask

    task automatic t_reset_and_arm();
        chk("R1", {31'd0, rd_valid_o}, 32'd0);
        chk("R1", {31'd0, running_o}, 32'd0);
        chk("R1", cur_base_o, 32'd0);
        next_base_i = 32'h0000_0700;
        xfer_count_i = {16'd2, 16'd2};
        start_frame();
        chk("R12", {31'd0, rd_valid_o}, 32'd0);
        chk("R12", cur_base_o, 32'd0);
        run_i = 1'b1;
        step();
        chk("R12", {31'd0, running_o}, 32'd1);
    endtask

    task automatic t_wide();
        next_base_i = 32'h0000_1000;
        xfer_count_i = {16'd3, 16'd4};
        wide_pix_i = 1'b1;
        start_frame();
        chk("R5", cur_base_o, 32'h0000_1000);
        walk_frame(32'h0000_1000, 4, 3, 1'b1, 1'b0);
    endtask

    task automatic t_narrow();
        next_base_i = 32'h0000_2000;
        xfer_count_i = {16'd2, 16'd6};
        wide_pix_i = 1'b0;
        start_frame();
        walk_frame(32'h0000_2000, 6, 2, 1'b0, 1'b1);
        next_base_i = 32'h0000_3000;
        xfer_count_i = {16'd2, 16'd5};
        start_frame();
        walk_frame(32'h0000_3000, 5, 2, 1'b0, 1'b0);
        wide_pix_i = 1'b1;
    endtask

    task automatic t_shadow_and_clear();
        next_base_i = 32'h0000_5000;
        xfer_count_i = {16'd2, 16'd2};
        start_frame();
        chk("R3", rd_addr_o, 32'h0000_5000);
        next_base_i = 32'h0000_9000;
        xfer_count_i = {16'd8, 16'd8};
        frame_start_i = 1'b1;
        step();
        frame_start_i = 1'b0;
        chk("R6", cur_base_o, 32'h0000_5000);
        chk("R5", rd_addr_o, 32'h0000_5004);
        step();
        chk("R8", rd_addr_o, 32'h0000_5008);
        step();
        chk("R8", rd_addr_o, 32'h0000_500C);
        step();
        chk("R8", {31'd0, rd_valid_o}, 32'd0);
        chk("R5", cur_base_o, 32'h0000_5000);
        start_frame();
        chk("R5", cur_base_o, 32'h0000_9000);
        chk("R5", rd_addr_o, 32'h0000_9000);
        step();
        chk("R3", rd_addr_o, 32'h0000_9004);
        fifo_clear_i = 1'b1;
        step();
        fifo_clear_i = 1'b0;
        chk("R10", {31'd0, rd_valid_o}, 32'd0);
        step();
        step();
        chk("R10", {31'd0, rd_valid_o}, 32'd0);
        next_base_i = 32'h0000_A000;
        xfer_count_i = {16'd1, 16'd2};
        start_frame();
        chk("R10", rd_addr_o, 32'h0000_A000);
        step();
        chk("R10", rd_addr_o, 32'h0000_A004);
        step();
        chk("R10", {31'd0, rd_valid_o}, 32'd0);
    endtask

    task automatic t_empty();
        next_base_i = 32'h0000_B000;
        xfer_count_i = {16'd0, 16'd4};
        start_frame();
        chk("R11", cur_base_o, 32'h0000_B000);
        chk("R11", {31'd0, rd_valid_o}, 32'd0);
        step();
        chk("R11", {31'd0, rd_valid_o}, 32'd0);
    endtask

    task automatic t_stop();
        next_base_i = 32'h0000_C000;
        xfer_count_i = {16'd4, 16'd4};
        start_frame();
        step();
        chk("R9", rd_addr_o, 32'h0000_C004);
        run_i = 1'b0;
        step();
        chk("R9", {31'd0, rd_valid_o}, 32'd0);
        chk("R9", {31'd0, running_o}, 32'd1);
        for (int k = 0; k < 3; k++) step();
        chk("R9", {31'd0, running_o}, 32'd1);
        fifo_empty_i = 1'b1;
        step();
        chk("R9", {31'd0, running_o}, 32'd0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_and_arm();
        t_wide();
        t_narrow();
        t_shadow_and_clear();
        t_empty();
        t_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule